// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block keeps an SDRAM refreshed and moves it into and out of its low-power self-refresh state. A free-running interval timer raises one refresh request per period. The period is the refresh interval in nanoseconds times the clock frequency in MHz, divided by 1000. Requests accumulate in a bounded backlog while the main controller reports itself busy. When the controller is free, or when the backlog is full, the sequencer takes the command bus. It precharges all banks, waits the row-precharge time, and then issues one AUTO REFRESH per owed request, spaced by the refresh cycle time. It then hands the bus back.

A sleep request closes all banks and issues the refresh command with the clock-enable pin driven low in the same cycle. The clock enable then stays low. A wake request is held until the device has stayed in self refresh for the minimum active time and the clock is reported stable. The sequencer then raises the clock enable and issues NOPs for the exit time before it releases the bus. All timing values are given in nanoseconds and converted to whole clock cycles, rounding up.

Top module: `sdram_refresh_seq`

## Requirements
- R1: The command output `cmd_o` is {ras_n, cas_n, we_n}. NOP is 3'b111, precharge is 3'b010 and refresh is 3'b001. `a10_o` is 1 on every precharge, so all banks close, and 0 on every other cycle. In reset the outputs are NOP, `cke_o`=1 and `busy_o`=0.
- R2: The interval timer is INTERVAL_CYC = REF_INTERVAL_NS*CLK_MHZ/1000 cycles, rounded down. With the host idle, successive refresh sequences begin exactly INTERVAL_CYC cycles apart.
- R3: Each sequence starts with a precharge. The first refresh follows exactly RP_CYC cycles later. Every X_CYC value is ceil(X_NS*CLK_MHZ/1000), with a minimum of 1.
- R4: After a refresh, the next refresh of the same sequence, or the fall of `busy_o`, comes exactly RFC_CYC cycles later (minimum 2). `busy_o` is high from the precharge cycle until the release.
- R5: While `host_busy` is 1 and the backlog is below MAX_PEND, no sequence starts and requests are counted. After release, one precharge is followed by one refresh per counted request.
- R6: When the backlog reaches MAX_PEND, a sequence starts even with `host_busy` at 1. It issues MAX_PEND refreshes, and the backlog never exceeds MAX_PEND.
- R7: `sleep_req`, with the block idle and `host_busy` at 0, gives a precharge and then, RP_CYC cycles later, a refresh with `cke_o` falling in that same cycle. `cke_o` falls at no other command. Sleep takes priority over owed refreshes.
- R8: `cke_o` stays low for at least RAS_CYC cycles. A `wake_req` pulse that arrives earlier is remembered. With `clk_stable` at 1, `cke_o` then rises exactly RAS_CYC cycles after the entry cycle.
- R9: `cke_o` is not raised while `clk_stable` is 0. It rises in the cycle after `clk_stable` is first sampled at 1 with a wake pending.
- R10: After `cke_o` rises, only NOPs are issued, and `busy_o` falls exactly XSR_CYC cycles later (minimum 2).
- R11: `wake_req` outside self refresh has no effect. `cke_o` stays 1 and `busy_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_busy | input | 1 | Main controller asks for refresh to be postponed |
| sleep_req | input | 1 | Request to enter self refresh (level, sampled when idle) |
| wake_req | input | 1 | Request to leave self refresh (pulse is remembered) |
| clk_stable | input | 1 | Memory clock is within its limits |
| cmd_o | output | 3 | {ras_n, cas_n, we_n} command |
| a10_o | output | 1 | Address bit 10, all-bank select on precharge |
| cke_o | output | 1 | Memory clock enable |
| busy_o | output | 1 | Sequencer owns the command bus |

## Verification
Every output is registered, so an input sampled at one clock edge shows its effect in the next cycle. Examples are the precharge after an idle-time request or a sleep request, and the `cke_o` rise after `clk_stable`. Later events are due at fixed distances from the event that caused them: the refresh RP_CYC cycles after the precharge, the next refresh or release RFC_CYC cycles after a refresh, the wake at RAS_CYC cycles after entry, and the release XSR_CYC cycles after the clock enable rises. A monitor samples on the falling edge, restarts a counter at each such event and compares the count for exact equality when the next event appears. Stimulus changes 1 ns after the falling edge, well away from the active edge.

// File: rtl/sdr_ref_pkg.sv
package sdr_ref_pkg;

  typedef enum logic [2:0] {
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_NOP = 3'b111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_RP,
    ST_WAIT_RFC,
    ST_SLEEP,
    ST_WAIT_XSR
  } seq_state_e;

  // nanoseconds to whole cycles, rounded up, never below lo
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned mhz,
                                         int unsigned lo);
    int unsigned c;
    c = (ns * mhz + 999) / 1000;
    return (c < lo) ? lo : c;
  endfunction

endpackage

// File: rtl/ref_tick_gen.sv
module ref_tick_gen #(
  parameter int unsigned PERIOD = 1562
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [PW-1:0] cnt_q;
  logic          tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == PW'(PERIOD - 1)) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + PW'(1);
      tick_q <= 1'b0;
    end
  end

  assign tick = tick_q;

endmodule

// File: rtl/ref_backlog.sv
module ref_backlog #(
  parameter int unsigned MAX_PEND = 8,
  localparam int unsigned BW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  input  logic          clr,
  output logic [BW-1:0] count,
  output logic          full
);
  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc && !dec) begin
      if (cnt_q != BW'(MAX_PEND)) cnt_q <= cnt_q + BW'(1);
    end else if (dec && !inc) begin
      if (cnt_q != '0) cnt_q <= cnt_q - BW'(1);
    end
  end

  assign count = cnt_q;
  assign full  = (cnt_q == BW'(MAX_PEND));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= BW'(MAX_PEND));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && !clr) |-> cnt_q != '0);

endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
  import sdr_ref_pkg::*;
#(
  parameter int unsigned CLK_MHZ         = 200,
  parameter int unsigned REF_INTERVAL_NS = 7812,
  parameter int unsigned T_RP_NS         = 18,
  parameter int unsigned T_RFC_NS        = 110,
  parameter int unsigned T_RAS_NS        = 45,
  parameter int unsigned T_XSR_NS        = 120,
  parameter int unsigned MAX_PEND        = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_busy,
  input  logic       sleep_req,
  input  logic       wake_req,
  input  logic       clk_stable,
  output logic [2:0] cmd_o,
  output logic       a10_o,
  output logic       cke_o,
  output logic       busy_o
);
  localparam int unsigned INTERVAL_CYC = REF_INTERVAL_NS * CLK_MHZ / 1000;
  localparam int unsigned RP_CYC  = ns2cyc(T_RP_NS,  CLK_MHZ, 1);
  localparam int unsigned RFC_CYC = ns2cyc(T_RFC_NS, CLK_MHZ, 2);
  localparam int unsigned RAS_CYC = ns2cyc(T_RAS_NS, CLK_MHZ, 1);
  localparam int unsigned XSR_CYC = ns2cyc(T_XSR_NS, CLK_MHZ, 2);
  localparam int unsigned M1   = (RP_CYC > RFC_CYC) ? RP_CYC : RFC_CYC;
  localparam int unsigned M2   = (RAS_CYC > XSR_CYC) ? RAS_CYC : XSR_CYC;
  localparam int unsigned TMAX = (M1 > M2) ? M1 : M2;
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam int unsigned BW   = $clog2(MAX_PEND + 1);
  localparam logic [TW-1:0] RP_V  = TW'(RP_CYC - 1);
  localparam logic [TW-1:0] RFC_V = TW'(RFC_CYC - 1);
  localparam logic [TW-1:0] RAS_V = TW'(RAS_CYC - 1);
  localparam logic [TW-1:0] XSR_V = TW'(XSR_CYC - 1);

  seq_state_e    state_q, state_d;
  sdr_cmd_e      cmd_q, cmd_d;
  logic          a10_q, a10_d;
  logic          cke_q, cke_d;
  logic          busy_q, busy_d;
  logic          sr_q, sr_d;     // current sequence ends in self refresh
  logic          wake_q;         // remembered wake request
  logic          tick;
  logic          dec;
  logic          full;
  logic [BW-1:0] pend;
  logic          tmr_ld;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;
  logic          ref_due;

  ref_tick_gen #(.PERIOD(INTERVAL_CYC)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  // self refresh refreshes on its own: owed requests are dropped
  ref_backlog #(.MAX_PEND(MAX_PEND)) u_backlog (
    .clk  (clk),
    .rst  (rst),
    .inc  (tick),
    .dec  (dec),
    .clr  (sr_q),
    .count(pend),
    .full (full)
  );

  seq_timer #(.W(TW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_ld),
    .load_val(tmr_val),
    .zero    (tmr_zero)
  );

  assign ref_due = (pend != '0) && (!host_busy || full);

  always_comb begin
    state_d = state_q;
    cmd_d   = CMD_NOP;
    a10_d   = 1'b0;
    cke_d   = cke_q;
    busy_d  = busy_q;
    sr_d    = sr_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    dec     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if ((sleep_req && !host_busy) || ref_due) begin
          cmd_d   = CMD_PRE;
          a10_d   = 1'b1;
          busy_d  = 1'b1;
          sr_d    = sleep_req && !host_busy;
          tmr_ld  = 1'b1;
          tmr_val = RP_V;
          state_d = ST_WAIT_RP;
        end
      end
      ST_WAIT_RP: begin
        if (tmr_zero) begin
          cmd_d  = CMD_REF;
          tmr_ld = 1'b1;
          if (sr_q) begin
            cke_d   = 1'b0;
            tmr_val = RAS_V;
            state_d = ST_SLEEP;
          end else begin
            dec     = 1'b1;
            tmr_val = RFC_V;
            state_d = ST_WAIT_RFC;
          end
        end
      end
      ST_WAIT_RFC: begin
        if (tmr_zero) begin
          if (pend != '0) begin
            cmd_d   = CMD_REF;
            dec     = 1'b1;
            tmr_ld  = 1'b1;
            tmr_val = RFC_V;
          end else begin
            busy_d  = 1'b0;
            state_d = ST_IDLE;
          end
        end
      end
      ST_SLEEP: begin
        if (tmr_zero && wake_q && clk_stable) begin
          cke_d   = 1'b1;
          tmr_ld  = 1'b1;
          tmr_val = XSR_V;
          state_d = ST_WAIT_XSR;
        end
      end
      ST_WAIT_XSR: begin
        if (tmr_zero) begin
          busy_d  = 1'b0;
          sr_d    = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cmd_q   <= CMD_NOP;
      a10_q   <= 1'b0;
      cke_q   <= 1'b1;
      busy_q  <= 1'b0;
      sr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      a10_q   <= a10_d;
      cke_q   <= cke_d;
      busy_q  <= busy_d;
      sr_q    <= sr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !sr_q) wake_q <= 1'b0;
    else if (wake_req) wake_q <= 1'b1;
  end

  assign cmd_o  = cmd_q;
  assign a10_o  = a10_q;
  assign cke_o  = cke_q;
  assign busy_o = busy_q;

  assert_pre_all_banks_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE) |-> a10_q);

  assert_ref_then_nop_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_REF) |=> (cmd_q == CMD_NOP));

  assert_cke_fall_on_ref_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(cke_q) |-> (cmd_q == CMD_REF));

  assert_sleep_owns_bus_R7: assert property (@(posedge clk) disable iff (rst)
    !cke_q |-> busy_q);

  assert_cke_rise_stable_clk_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(cke_q) |-> $past(clk_stable));

  assert_exit_nop_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(cke_q) |-> (cmd_q == CMD_NOP));

endmodule

// File: tb/sdram_refresh_seq_tb.sv
`timescale 1ns/100ps
module sdram_refresh_seq_tb;
  localparam int CLK_MHZ = 200;
  localparam int IVL_NS = 500, RP_NS = 15, RFC_NS = 40, RAS_NS = 45, XSR_NS = 20;
  localparam int MAXP = 4;
  localparam int IVL = IVL_NS * CLK_MHZ / 1000;
  localparam int RP  = (RP_NS  * CLK_MHZ + 999) / 1000;
  localparam int RFC = (RFC_NS * CLK_MHZ + 999) / 1000;
  localparam int RAS = (RAS_NS * CLK_MHZ + 999) / 1000;
  localparam int XSR = (XSR_NS * CLK_MHZ + 999) / 1000;
  localparam logic [2:0] C_NOP = 3'b111, C_PRE = 3'b010, C_REF = 3'b001;
  // {ticks held off by host_busy, refreshes expected in the following burst}
  localparam int VEC [3][2] = '{'{1, 1}, '{2, 2}, '{3, 3}};

  logic clk = 0, rst = 1;
  logic host_busy = 0, sleep_req = 0, wake_req = 0, clk_stable = 1;
  logic [2:0] cmd_o;
  logic a10_o, cke_o, busy_o;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdram_refresh_seq #(
    .CLK_MHZ(CLK_MHZ), .REF_INTERVAL_NS(IVL_NS), .T_RP_NS(RP_NS),
    .T_RFC_NS(RFC_NS), .T_RAS_NS(RAS_NS), .T_XSR_NS(XSR_NS), .MAX_PEND(MAXP)
  ) u_dut (
    .clk(clk), .rst(rst), .host_busy(host_busy), .sleep_req(sleep_req),
    .wake_req(wake_req), .clk_stable(clk_stable), .cmd_o(cmd_o),
    .a10_o(a10_o), .cke_o(cke_o), .busy_o(busy_o)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: event spacing measured with counters restarted at each event
  int cyc = 0, since_pre = 0, since_ref = 0, since_sl = 0, since_rise = 0;
  int ep_refs = 0, last_burst = 0, rise_sl = 0, pre_cyc = 0;
  int n_pre = 0, n_ends = 0, pre_hb = 0;
  bit ep_first_cke = 1, slept = 0, prev_cke = 1, prev_busy = 0;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++; since_pre++; since_ref++; since_sl++; since_rise++;
      if (cmd_o == C_PRE) begin
        chk(a10_o == 1'b1, "R1", a10_o, 1);
        since_pre = 0; ep_refs = 0; pre_cyc = cyc; n_pre++;
        if (host_busy) pre_hb++;
      end else if (a10_o) chk(0, "R1", 1, 0);
      if (cmd_o == C_REF) begin
        if (ep_refs == 0) begin
          chk(since_pre == RP, "R3", since_pre, RP);
          ep_first_cke = cke_o;
        end else chk(since_ref == RFC, "R4", since_ref, RFC);
        ep_refs++; since_ref = 0;
      end
      if (prev_cke && !cke_o) begin
        chk(cmd_o == C_REF, "R7", cmd_o, C_REF);
        since_sl = 0; slept = 1;
      end
      if (!prev_cke && cke_o) begin
        chk(since_sl >= RAS, "R8", since_sl, RAS);
        rise_sl = since_sl; since_rise = 0;
      end
      if (slept && cke_o && busy_o && cmd_o != C_NOP) chk(0, "R10", cmd_o, C_NOP);
      if (prev_busy && !busy_o) begin
        if (slept) chk(since_rise == XSR, "R10", since_rise, XSR);
        else       chk(since_ref == RFC, "R4", since_ref, RFC);
        last_burst = ep_refs; slept = 0; n_ends++;
      end
      prev_cke = cke_o; prev_busy = busy_o;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_end(string req, int lim);
    int s = n_ends;
    for (int k = 0; k < lim && n_ends == s; k++) step();
    if (n_ends == s) chk(0, req, 0, 1);
  endtask

  task automatic wait_cke(bit lvl, string req, int lim);
    for (int k = 0; k < lim && cke_o != lvl; k++) step();
    if (cke_o != lvl) chk(0, req, cke_o, lvl);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (4) step();
    // R1 reset state
    chk(cmd_o == C_NOP, "R1", cmd_o, C_NOP);
    chk(cke_o == 1'b1, "R1", cke_o, 1);
    chk(busy_o == 1'b0, "R1", busy_o, 0);
    chk(a10_o == 1'b0, "R1", a10_o, 0);
    rst = 0;

    // R2 idle refresh spacing
    begin
      int s = n_pre, p1;
      while (n_pre == s) step();
      p1 = pre_cyc;
      while (n_pre == s + 1) step();
      chk(pre_cyc - p1 == IVL, "R2", pre_cyc - p1, IVL);
    end

    // R11 wake outside self refresh
    wait_end("R11", 3 * IVL);
    wake_req = 1; step(); wake_req = 0;
    begin
      bit ok = 1;
      repeat (6) begin step(); ok &= cke_o && !busy_o; end
      chk(ok, "R11", ok, 1);
    end

    // R5 postponed refreshes, table driven
    for (int i = 0; i < 3; i++) begin
      int pb;
      wait_end("R5", 3 * IVL);
      host_busy = 1; pb = pre_hb;
      repeat (VEC[i][0] * IVL) step();
      chk(pre_hb == pb, "R5", pre_hb - pb, 0);
      host_busy = 0;
      wait_end("R5", IVL);
      chk(last_burst == VEC[i][1], "R5", last_burst, VEC[i][1]);
    end

    // R6 forced refresh at a full backlog
    begin
      int pb;
      wait_end("R6", 3 * IVL);
      host_busy = 1; pb = pre_hb;
      wait_end("R6", (MAXP + 1) * IVL);
      chk(pre_hb == pb + 1, "R6", pre_hb - pb, 1);
      chk(last_burst == MAXP, "R6", last_burst, MAXP);
      host_busy = 0;
    end

    // R8 early wake is held until the minimum residency
    wait_end("R8", 3 * IVL);
    sleep_req = 1;
    wait_cke(0, "R7", 50);
    sleep_req = 0;
    step(); wake_req = 1; step(); wake_req = 0;
    wait_cke(1, "R8", 100);
    chk(rise_sl == RAS, "R8", rise_sl, RAS);
    wait_end("R10", 50);

    // R9 clock enable waits for a stable clock
    sleep_req = 1;
    wait_cke(0, "R9", 50);
    sleep_req = 0; clk_stable = 0;
    wake_req = 1; step(); wake_req = 0;
    repeat (RAS + 5) step();
    chk(cke_o == 1'b0, "R9", cke_o, 0);
    clk_stable = 1; step();
    chk(cke_o == 1'b1, "R9", cke_o, 1);
    wait_end("R10", 50);

    // R7 sleep wins over owed refreshes
    wait_end("R7", 3 * IVL);
    host_busy = 1;
    repeat (2 * IVL) step();
    host_busy = 0; sleep_req = 1;
    wait_cke(0, "R7", 50);
    sleep_req = 0;
    chk(ep_first_cke == 1'b0 && ep_refs == 1, "R7", ep_refs, 1);
    wake_req = 1; step(); wake_req = 0;
    wait_end("R10", 100);

    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

endmodule